// File: doc/BRIEF.md
# Interval Pulse Generator

This block derives periodic pulse trains, such as a once-per-second marker or a 10 kHz reference, from a precision time clock. The clock supplies a tick strobe and the tick's length in nanoseconds. Two generators with identical logic run independently. Each generator holds a programmed interval in nanoseconds and counts it down by the tick length on every tick strobe. When the count would drop below zero, the generator reloads from its interval, drives its pulse line high and raises a sticky event flag.

The interval is programmed as one tick length less than the wanted period. A 10 ns tick with an interval of 999,999,990 therefore gives one pulse per second. The same tick with an interval of 99,990 gives 10 kHz. Each pulse lasts one period of the output clock, which is the tick rate divided by a prescale value that both generators share. The pulse is therefore `prescale` ticks long. Software clears a flag by writing one to its bit.

Top module: `interval_pulse_gen`

## Requirements
- R1: An armed generator fires once every floor(interval / tickPeriod) + 1 tick strobes. With tickPeriod 10 and interval 99,990 it fires every 10,000 ticks; with interval 999,999,990 it fires every 100,000,000 ticks.
- R2: A pulse stays high for exactly `prescale` tick strobes, counting the strobe that starts it. A prescale of 0 behaves as 1.
- R3: The countdown, the pulse start and the pulse end all advance only on cycles where tickStb is 1. Cycles without a strobe change nothing except a flag clear.
- R4: While its enable bit is 0, a generator holds its pulse low and keeps its countdown loaded with the interval. Counting starts with the first strobe at least one cycle after the enable is sampled high, so the first pulse comes a full period after arming. Reset is treated the same as a disabled generator.
- R5: A generator's event flag is 1 in the same cycle that its pulse first becomes high.
- R6: An event flag stays 1 until a 1 is written to the matching bit of evtClr. It then reads 0 in the next cycle.
- R7: If a firing and a clear of the same flag fall in the same cycle, the flag stays 1.
- R8: Bit 0 of every vector port belongs to generator 0 and bit 1 to generator 1. Neither generator's inputs affect the other's outputs.
- R9: A firing that happens while a pulse is still high restarts the pulse width at `prescale` ticks.
- R10: After reset, both pulse lines and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickStb | input | 1 | Time clock tick strobe |
| tickPeriod | input | 8 | Length of one tick in ns |
| prescale | input | 16 | Output clock divider, sets pulse width in ticks |
| interval0 | input | 32 | Generator 0 interval (period minus one tick, ns) |
| interval1 | input | 32 | Generator 1 interval (period minus one tick, ns) |
| enable | input | 2 | Per-generator enable |
| evtClr | input | 2 | Write-one-to-clear strobe per flag |
| pulseOut | output | 2 | Pulse lines |
| evtFlag | output | 2 | Sticky event flags |

## Verification
The two functions that can land in the same cycle are the setting of a flag by a firing and its clearing by a write of one. A bench model predicts the cycle of each firing. A directed phase drives evtClr exactly in that cycle, and the flag is expected to read 1 afterwards. Random phases also collide clears with firings, and retriggers with pulses still running. Every cycle is compared against the model.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  // Strobes from the control to one datapath lane.
  typedef struct packed {
    logic hold;      // disabled or arming: reload countdown, drop pulse
    logic step;      // subtract one tick from the countdown
    logic fire;      // countdown exhausted: reload and start a pulse
    logic widthStep; // pulse running: consume one tick of width
    logic pulseEnd;  // pulse width used up: drop the pulse
  } ipgCtrl_t;
endpackage

// File: rtl/ipg_dpath.sv
module ipg_dpath
  import ipg_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TICK_W = 8,
  parameter int PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipgCtrl_t          ctrl,
  input  logic [TICK_W-1:0] tickPeriod,
  input  logic [PRSC_W-1:0] prescale,
  input  logic [CNT_W-1:0]  interval,
  output logic              cntUnder,
  output logic              widthDone,
  output logic              pulseOn
);
  localparam int EXT_W = CNT_W - TICK_W;

  logic [CNT_W-1:0]  remain;
  logic [PRSC_W-1:0] widthLeft;
  logic [CNT_W-1:0]  tickExt;
  logic [PRSC_W-1:0] widthLoad;

  assign tickExt   = {{EXT_W{1'b0}}, tickPeriod};
  assign widthLoad = (prescale == '0) ? '0 : prescale - 1'b1;

  // Status toward the control.
  assign cntUnder  = remain < tickExt;
  assign widthDone = widthLeft == '0;

  // Interval countdown.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (ctrl.hold || ctrl.fire) begin
      remain <= interval;
    end else if (ctrl.step) begin
      remain <= remain - tickExt;
    end
  end

  // Pulse width counter and pulse register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthLeft <= '0;
      pulseOn   <= 1'b0;
    end else if (ctrl.hold) begin
      widthLeft <= '0;
      pulseOn   <= 1'b0;
    end else if (ctrl.fire) begin
      widthLeft <= widthLoad;
      pulseOn   <= 1'b1;
    end else if (ctrl.pulseEnd) begin
      pulseOn   <= 1'b0;
    end else if (ctrl.widthStep) begin
      widthLeft <= widthLeft - 1'b1;
    end
  end
endmodule

// File: rtl/ipg_ctrl.sv
module ipg_ctrl
  import ipg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickStb,
  input  logic     enable,
  input  logic     evtClr,
  input  logic     cntUnder,
  input  logic     widthDone,
  input  logic     pulseOn,
  output ipgCtrl_t ctrl,
  output logic     evtFlag
);
  logic armed;
  logic running;
  logic tickRun;

  // A generator runs only after the enable has been seen for one cycle.
  assign running = enable && armed;
  assign tickRun = running && tickStb;

  always_comb begin
    ctrl           = '0;
    ctrl.hold      = !running;
    ctrl.fire      = tickRun && cntUnder;
    ctrl.step      = tickRun && !cntUnder;
    ctrl.pulseEnd  = tickRun && !cntUnder && pulseOn && widthDone;
    ctrl.widthStep = tickRun && !cntUnder && pulseOn && !widthDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else begin
      armed <= enable;
    end
  end

  // Sticky flag: a firing outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFlag <= 1'b0;
    end else if (ctrl.fire) begin
      evtFlag <= 1'b1;
    end else if (evtClr) begin
      evtFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen
  import ipg_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int TICK_W  = 8,
  parameter int PRSC_W  = 16,
  parameter int NUM_GEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStb,
  input  logic [TICK_W-1:0] tickPeriod,
  input  logic [PRSC_W-1:0] prescale,
  input  logic [CNT_W-1:0]  interval0,
  input  logic [CNT_W-1:0]  interval1,
  input  logic [NUM_GEN-1:0] enable,
  input  logic [NUM_GEN-1:0] evtClr,
  output logic [NUM_GEN-1:0] pulseOut,
  output logic [NUM_GEN-1:0] evtFlag
);
  logic [CNT_W-1:0] intervalArr [NUM_GEN];

  // Map the interval ports onto lanes; extra lanes reuse the last one.
  generate
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_map
      if (g == 0) begin : g_first
        assign intervalArr[g] = interval0;
      end else begin : g_rest
        assign intervalArr[g] = interval1;
      end
    end
  endgenerate

  generate
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_lane
      ipgCtrl_t ctrl;
      logic     cntUnder;
      logic     widthDone;
      logic     pulseOn;

      ipg_ctrl u_ctrl (
        .clk       (clk),
        .rstN      (rstN),
        .tickStb   (tickStb),
        .enable    (enable[g]),
        .evtClr    (evtClr[g]),
        .cntUnder  (cntUnder),
        .widthDone (widthDone),
        .pulseOn   (pulseOn),
        .ctrl      (ctrl),
        .evtFlag   (evtFlag[g])
      );

      ipg_dpath #(
        .CNT_W  (CNT_W),
        .TICK_W (TICK_W),
        .PRSC_W (PRSC_W)
      ) u_dpath (
        .clk        (clk),
        .rstN       (rstN),
        .ctrl       (ctrl),
        .tickPeriod (tickPeriod),
        .prescale   (prescale),
        .interval   (intervalArr[g]),
        .cntUnder   (cntUnder),
        .widthDone  (widthDone),
        .pulseOn    (pulseOn)
      );

      assign pulseOut[g] = pulseOn;
    end
  endgenerate
endmodule

// File: rtl/interval_pulse_gen_chk.sv
module interval_pulse_gen_chk #(
  parameter int NUM_GEN = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               tickStb,
  input logic [NUM_GEN-1:0] enable,
  input logic [NUM_GEN-1:0] evtClr,
  input logic [NUM_GEN-1:0] pulseOut,
  input logic [NUM_GEN-1:0] evtFlag
);
  generate
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
      AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
        !enable[g] |=> !pulseOut[g]); // R4
      AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pulseOut[g]) |-> $past(tickStb) && $past(enable[g])); // R3
      AST_FALL_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
        $fell(pulseOut[g]) |-> $past(tickStb) || !$past(enable[g])); // R3
      AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pulseOut[g]) |-> evtFlag[g]); // R5
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        $fell(evtFlag[g]) |-> $past(evtClr[g])); // R6
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pulseOut[g]) && $past(evtClr[g]) |-> evtFlag[g]); // R7
    end
  endgenerate
endmodule

bind interval_pulse_gen interval_pulse_gen_chk #(.NUM_GEN(NUM_GEN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickStb  (tickStb),
  .enable   (enable),
  .evtClr   (evtClr),
  .pulseOut (pulseOut),
  .evtFlag  (evtFlag)
);

// File: tb/interval_pulse_gen_tb.sv
module interval_pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickStb = 1'b0;
  logic [7:0]  tickPeriod = 8'd10;
  logic [15:0] prescale = 16'd1;
  logic [31:0] interval0 = '0;
  logic [31:0] interval1 = '0;
  logic [1:0]  enable = '0;
  logic [1:0]  evtClr = '0;
  logic [1:0]  pulseOut;
  logic [1:0]  evtFlag;

  int errors = 0;
  int checks = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interval_pulse_gen u_dut (
    .clk(clk), .rstN(rstN), .tickStb(tickStb), .tickPeriod(tickPeriod),
    .prescale(prescale), .interval0(interval0), .interval1(interval1),
    .enable(enable), .evtClr(evtClr), .pulseOut(pulseOut), .evtFlag(evtFlag)
  );

  // Reference model built from the requirements.
  logic [31:0] mCnt [2];
  logic [15:0] mWid [2];
  logic [1:0]  mPulse, mFlag, mArmed;

  function automatic logic [31:0] intvOf(int g);
    return (g == 0) ? interval0 : interval1;
  endfunction

  function automatic bit fireNext(int g);
    return enable[g] && mArmed[g] && tickStb && (mCnt[g] < {24'd0, tickPeriod});
  endfunction

  function automatic logic [15:0] widthLoad();
    return (prescale == 0) ? 16'd0 : prescale - 16'd1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < 2; g++) begin
        mCnt[g] <= '0;
        mWid[g] <= '0;
      end
      mPulse <= '0; mFlag <= '0; mArmed <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        bit f;
        f = fireNext(g);
        mArmed[g] <= enable[g];
        if (f) mFlag[g] <= 1'b1;
        else if (evtClr[g]) mFlag[g] <= 1'b0;
        if (!(enable[g] && mArmed[g])) begin
          mCnt[g] <= intvOf(g); mPulse[g] <= 1'b0; mWid[g] <= '0;
        end else if (tickStb) begin
          if (f) begin
            mCnt[g] <= intvOf(g); mPulse[g] <= 1'b1; mWid[g] <= widthLoad();
          end else begin
            mCnt[g] <= mCnt[g] - {24'd0, tickPeriod};
            if (mPulse[g]) begin
              if (mWid[g] == 0) mPulse[g] <= 1'b0;
              else mWid[g] <= mWid[g] - 16'd1;
            end
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R3, R6, R8, R9).
  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      check(pulseOut == mPulse, "R3/R9 pulse vs model", pulseOut, mPulse);
      check(evtFlag == mFlag, "R6/R8 flag vs model", evtFlag, mFlag);
    end
  end

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish();
  end

  initial begin : stim
    int rise1, rise2, width, n;
    logic prev;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(pulseOut == 2'b00, "R10 pulse after reset", pulseOut, 0);
    check(evtFlag == 2'b00, "R10 flag after reset", evtFlag, 0);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;

    // R1/R2/R4: 10 kHz train from a 10 ns tick, width 5 ticks, gen1 idle.
    tickStb = 1'b1; tickPeriod = 8'd10; prescale = 16'd5;
    interval0 = 32'd99990; interval1 = 32'd40;
    enable = 2'b01;
    rise1 = 0; rise2 = 0; width = 0; prev = 1'b0; n = 0;
    while (rise2 == 0 && n < 25000) begin
      @(negedge clk); n++;
      if (pulseOut[0] && !prev) begin
        if (rise1 == 0) rise1 = n; else rise2 = n;
      end
      if (pulseOut[0] && rise2 == 0) width++;
      check(pulseOut[1] == 1'b0, "R8 idle generator stays low", pulseOut[1], 0);
      prev = pulseOut[0];
    end
    check(rise1 == 10001, "R4 first pulse one period after arming", rise1, 10001);
    check(rise2 - rise1 == 10000, "R1 period 10000 ticks", rise2 - rise1, 10000);
    check(width == 5, "R2 width equals prescale", width, 5);
    check(evtFlag == 2'b01, "R5 flag set by firing", evtFlag, 1);

    // R6: write one to clear.
    evtClr = 2'b01; @(negedge clk); evtClr = 2'b00;
    check(evtFlag[0] == 1'b0, "R6 flag cleared", evtFlag[0], 0);

    // R4: disabled generator ignores ticks.
    enable = 2'b00;
    repeat (50) begin
      @(negedge clk);
      check(pulseOut == 2'b00, "R4 disabled pulse low", pulseOut, 0);
    end

    // R7: clear exactly on the firing cycle.
    interval0 = 32'd30; interval1 = 32'd50; prescale = 16'd2; enable = 2'b11;
    n = 0;
    repeat (200) begin
      @(negedge clk);
      evtClr = 2'b00;
      for (int g = 0; g < 2; g++) if (fireNext(g)) evtClr[g] = 1'b1;
      if (evtClr != 0) begin
        logic [1:0] hit;
        hit = evtClr;
        @(negedge clk);
        evtClr = 2'b00;
        check((evtFlag & hit) == hit, "R7 set beats clear", evtFlag, hit);
        n++;
      end
    end
    check(n > 3, "R7 collisions provoked", n, 4);

    // Random phases: tick density, periods, widths, enables and clears.
    for (int ph = 0; ph < 6; ph++) begin
      int dens;
      dens = 20 + ph * 15;
      tickPeriod = 8'($urandom_range(1, 16));
      prescale   = 16'($urandom_range(0, 9));
      interval0  = $urandom_range(0, 300);
      interval1  = $urandom_range(0, 300);
      repeat (3000) begin
        @(negedge clk);
        tickStb = ($urandom_range(0, 99) < dens);
        evtClr  = 2'($urandom_range(0, 3)) & {$urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0};
        if ($urandom_range(0, 299) == 0) enable = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 999) == 0) interval1 = $urandom_range(0, 300);
      end
      enable = 2'b11;
    end
    @(negedge clk);
    finish();
  end
endmodule